// File: doc/BRIEF.md
# Strobed I/O Port Line Decoder

This block turns a small binary command code from a processor into one of several separate active-high enable lines for a peripheral board. The code is latched when the first timing strobe of a machine cycle is sampled. From then until the second timing strobe has finished, the line that matches the latched code is driven high. Code zero is a defined "no device" value and drives no line.

The lines exist only inside that window. Before the first strobe and after the second strobe has ended, every line is low. A new first strobe during an open window starts a fresh window with a freshly latched code. The strobes and the code are sampled on the rising clock edge, and reset is synchronous.

Top module: `ioStrobeDecoder`

## Requirements
- R1: While reset is sampled high, and in the cycle after reset is released, all enable lines are low.
- R2: At a rising edge where `strobeA` is high, `cmdCode` is latched and the window opens. The decoded line shows from that edge on.
- R3: Changes on `cmdCode` while the window is open, with no new `strobeA`, do not change the enable lines.
- R4: A latched code of 0 keeps all seven lines low for the whole window.
- R5: A latched code n in 1..7 drives `portEn[n-1]` high and every other bit low. Bit 0 is line 1 and bit 6 is line 7.
- R6: The selected line stays high through every cycle in which `strobeB` is sampled high. It drops at the first rising edge that samples `strobeB` low after it was sampled high in the window.
- R7: With no open window, all lines are low. This holds before any `strobeA`, after a window closes, and when `strobeB` arrives with no window open.
- R8: A `strobeA` while a window is open replaces the latched code at once and restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobeA | input | 1 | First timing strobe; latches the code and opens the window |
| strobeB | input | 1 | Second timing strobe; the window ends after it falls |
| cmdCode | input | 3 | Command code selecting the port line |
| portEn | output | 7 | Active-high port enable lines 1..7 |

## Verification
Every result is due one rising edge after the inputs that cause it. A latched code shows on `portEn` right after the edge that samples `strobeA`. The window closes right after the first edge that samples `strobeB` low following a high sample. The bench drives inputs on the falling edge, queues the value expected after the next rising edge, and has the monitor compare that value 1 ns after the rising edge. Each queued item therefore lines up with exactly one edge and cannot drift.

// File: rtl/ioStrobeDecoderPkg.sv
package ioStrobeDecoderPkg;
  // strobes from the window control to the code datapath
  typedef struct packed {
    logic capture;  // latch the command code this edge
    logic active;   // window open, decoded line may show
  } ctlStrobes_t;
endpackage

// File: rtl/ioDecCtrl.sv
module ioDecCtrl
  import ioStrobeDecoderPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        strobeA,
  input  logic        strobeB,
  output ctlStrobes_t ctl
);
  logic windowOpen;
  logic bSeen;
  logic closeNow;

  // close once strobeB has been seen high and is now low
  assign closeNow = windowOpen && bSeen && !strobeB;

  always_ff @(posedge clk) begin
    if (rst) begin
      windowOpen <= 1'b0;
      bSeen      <= 1'b0;
    end else if (strobeA) begin
      windowOpen <= 1'b1;
      bSeen      <= 1'b0;
    end else if (closeNow) begin
      windowOpen <= 1'b0;
      bSeen      <= 1'b0;
    end else if (windowOpen && strobeB) begin
      bSeen      <= 1'b1;
    end
  end

  always_comb begin
    ctl.capture = strobeA && !rst;
    ctl.active  = windowOpen;
  end
endmodule

// File: rtl/ioDecPath.sv
module ioDecPath
  import ioStrobeDecoderPkg::*;
#(
  parameter int CODE_W = 3,
  parameter int LINES  = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cmdCode,
  input  ctlStrobes_t       ctl,
  output logic [LINES-1:0]  portEn
);
  logic [CODE_W-1:0] heldCode;

  always_ff @(posedge clk) begin
    if (rst)              heldCode <= '0;
    else if (ctl.capture) heldCode <= cmdCode;
  end

  // line i+1 matches code i+1; code zero matches no line
  for (genvar i = 0; i < LINES; i++) begin : gLine
    assign portEn[i] = ctl.active && (heldCode == CODE_W'(i + 1));
  end
endmodule

// File: rtl/ioStrobeDecoder.sv
module ioStrobeDecoder
  import ioStrobeDecoderPkg::*;
#(
  parameter int CODE_W = 3,
  parameter int LINES  = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobeA,
  input  logic              strobeB,
  input  logic [CODE_W-1:0] cmdCode,
  output logic [LINES-1:0]  portEn
);
  ctlStrobes_t ctl;

  ioDecCtrl uCtrl (
    .clk(clk), .rst(rst), .strobeA(strobeA), .strobeB(strobeB), .ctl(ctl)
  );

  ioDecPath #(.CODE_W(CODE_W), .LINES(LINES)) uPath (
    .clk(clk), .rst(rst), .cmdCode(cmdCode), .ctl(ctl), .portEn(portEn)
  );
endmodule

// File: rtl/ioStrobeDecoderChk.sv
module ioStrobeDecoderChk #(
  parameter int CODE_W = 3,
  parameter int LINES  = (1 << CODE_W) - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              strobeA,
  input logic              strobeB,
  input logic [CODE_W-1:0] cmdCode,
  input logic [LINES-1:0]  portEn
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $fell(rst) |-> portEn == '0);

  a_r5_one_line: assert property (@(posedge clk) disable iff (rst)
    $onehot0(portEn));

  a_r2_capture_line: assert property (@(posedge clk) disable iff (rst)
    (strobeA && cmdCode != '0) |=> portEn == LINES'(1 << ($past(cmdCode) - 1)));

  a_r4_zero_code: assert property (@(posedge clk) disable iff (rst)
    (strobeA && cmdCode == '0) |=> portEn == '0);

  a_r3_held: assert property (@(posedge clk) disable iff (rst)
    (portEn != '0 && !strobeA) |=> (portEn == $past(portEn) || portEn == '0));

  a_r6_through_b: assert property (@(posedge clk) disable iff (rst)
    (portEn != '0 && strobeB && !strobeA) |=> $stable(portEn));
endmodule

bind ioStrobeDecoder ioStrobeDecoderChk #(.CODE_W(CODE_W), .LINES(LINES)) uChk (.*);

// File: tb/sim_ioStrobeDecoder.sv
module sim_ioStrobeDecoder;
  typedef struct {
    logic [6:0] expVal;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobeA = 1'b0;
  logic       strobeB = 1'b0;
  logic [2:0] cmdCode = '0;
  logic [6:0] portEn;

  int checks = 0;
  int errors = 0;
  item_t sbq[$];

  // bench model state, written from the requirements
  logic       mWin = 1'b0;
  logic       mSeen = 1'b0;
  logic [2:0] mCode = '0;
  bit         done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ioStrobeDecoder u0 (
    .clk(clk), .rst(rst), .strobeA(strobeA), .strobeB(strobeB),
    .cmdCode(cmdCode), .portEn(portEn)
  );

  task automatic step(input logic r, input logic a, input logic b,
                      input logic [2:0] code, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; strobeA = a; strobeB = b; cmdCode = code;
    if (r) begin
      mWin = 0; mSeen = 0; mCode = '0;
    end else if (a) begin
      mWin = 1; mSeen = 0; mCode = code;
    end else if (mWin) begin
      if (b) mSeen = 1;
      else if (mSeen) begin mWin = 0; mSeen = 0; end
    end
    it.expVal = (mWin && mCode != 0) ? 7'(1 << (mCode - 1)) : 7'd0;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // one full window for a code: A, hold with code noise, B for two cycles, close
  task automatic window(input logic [2:0] code, input string tag);
    step(0, 1, 0, code, "R2");
    step(0, 0, 0, ~code, "R3");
    step(0, 0, 0, code ^ 3'd5, tag);
    step(0, 0, 1, 3'd0, "R6");
    step(0, 0, 1, 3'd7, "R6");
    step(0, 0, 0, code, "R6");
    step(0, 0, 0, code, "R7");
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (portEn !== it.expVal) begin
          errors++;
          $display("FAIL %s: portEn=%b expected=%b", it.tag, portEn, it.expVal);
        end
      end
    end
  end

  initial begin
    step(1, 0, 0, 3'd3, "R1");
    step(1, 1, 1, 3'd5, "R1");
    step(0, 0, 0, 3'd0, "R1");
    step(0, 0, 0, 3'd2, "R7");
    step(0, 0, 1, 3'd4, "R7");  // strobeB with no window
    step(0, 0, 0, 3'd4, "R7");
    for (int c = 1; c < 8; c++) window(3'(c), "R5");
    window(3'd0, "R4");
    // R8: recapture inside an open window
    step(0, 1, 0, 3'd2, "R2");
    step(0, 0, 0, 3'd2, "R3");
    step(0, 1, 0, 3'd6, "R8");
    step(0, 0, 1, 3'd1, "R8");
    step(0, 1, 1, 3'd3, "R8");  // A together with B: recapture wins
    step(0, 0, 0, 3'd3, "R8");  // fresh window, B not yet seen
    step(0, 0, 1, 3'd3, "R6");
    step(0, 0, 0, 3'd3, "R6");
    step(0, 0, 0, 3'd3, "R7");
    // R1: reset in the middle of a window
    step(0, 1, 0, 3'd7, "R2");
    step(1, 0, 0, 3'd7, "R1");
    step(0, 0, 0, 3'd7, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected=done", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule